// File: doc/BRIEF.md
# Four-Digit Decimal Event Counter with Multiplexed Seven-Segment Output

The block counts rising edges on an asynchronous event input and keeps the total as four BCD digits, from 0000 up to 9999 and then back round to 0000. An enable input gates the counting. A synchronous reset clears the count. Before an edge is recognised, the event input passes through a two-flop synchroniser and then a small edge-qualifying state machine. State EV_WAIT_LOW waits for the synchronised input to be low, and transition T_ARM then moves to EV_WAIT_HIGH. From EV_WAIT_HIGH, a high synchronised input takes transition T_FIRE back to EV_WAIT_LOW and produces exactly one event. Each BCD digit passes a carry to the next higher digit when it rolls from 9 to 0.

The count is shown on active-high seven-segment outputs, and a parameter selects one of two output arrangements. In scan mode, a single shared segment bus is time-multiplexed over four one-hot digit selects. A scan state machine with states SCAN_D0, SCAN_D1, SCAN_D2 and SCAN_D3 steps through the digits (transitions T_NEXT, wrapping from SCAN_D3 to SCAN_D0). It moves once every SCAN_DIV system clocks, counted by a prescaler. The segment bus is decoded from the digit that is currently selected, in the same cycle, so it never disagrees with the select. In parallel mode, every digit has its own seven-segment field and the scan outputs are held low.

Top module: `dec_scan_counter`

## Requirements
- R1: During reset and in the cycle after it the count reads 0000, dig_sel reads 0001 (digit 0 selected) in scan mode, and the scan prescaler restarts; an event input already high at reset is not counted until it has been seen low.
- R2: Each rising edge of evt_in, after two synchroniser flops, adds exactly one to the count while cnt_en is high; an input held high for many cycles counts once.
- R3: While cnt_en is low, edges on evt_in leave the count unchanged, and an edge seen while disabled is not counted later.
- R4: Each BCD digit counts 0 to 9; on the step from 9 it returns to 0 and increments the next digit (0009 to 0010, 0099 to 0100, 0999 to 1000).
- R5: From 9999 the next counted event gives 0000.
- R6: Segment encoding, bit 0 = a through bit 6 = g, active high: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R7: In scan mode dig_sel is always one-hot, bit k selecting digit k (bit 0 = least significant); after reset the selected index after n clocks is (n / SCAN_DIV) mod 4.
- R8: In scan mode seg_bus always carries the code of the digit picked by dig_sel in the same cycle.
- R9: In parallel mode seg_par[7k+6:7k] carries the code of digit k while seg_bus and dig_sel stay 0; in scan mode seg_par stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable, active high |
| evt_in | input | 1 | Asynchronous count-event input, rising edge counted |
| seg_bus | output | 7 | Shared segment bus (scan mode), bit 0 = a |
| dig_sel | output | 4 | One-hot digit select (scan mode), bit 0 = least significant digit |
| seg_par | output | 28 | Per-digit segment fields (parallel mode), digit k at bits 7k+6:7k |

## Verification
The checker watches every cycle for the following: the select stays one-hot; every change of the select is a single rotation step that comes exactly one dwell period after the last one; the segment bus only ever shows one of the ten legal digit codes; the count changes only by one decimal step, wrapping from 9999 to 0000; the count does not move while counting is disabled; and the outputs are in their reset values. The bench scenarios are what show the rest. A long-held input counts once. A disabled edge is consumed and not counted later. The carries propagate correctly through 0099, 0999 and 9999. The segment bus carries the right code for the value actually counted. The scan position follows the expected schedule measured from reset.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int NUM_DIGITS = 4;
    localparam int BCD_W      = 4;
    localparam int SEG_W      = 7;
    localparam int SEL_W      = $clog2(NUM_DIGITS);

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef enum logic {
        EV_WAIT_LOW,
        EV_WAIT_HIGH
    } ev_state_t;

    typedef enum logic [1:0] {
        SCAN_D0,
        SCAN_D1,
        SCAN_D2,
        SCAN_D3
    } scan_state_t;
endpackage

// File: rtl/dsc_event_qual.sv
module dsc_event_qual
    import dsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_raw,
    output logic evt_fire
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   evt_s;
    ev_state_t              state_q;
    ev_state_t              state_d;

    // synchroniser; preset high so a level present at reset is not an edge
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], evt_raw};
        end
    end

    assign evt_s = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EV_WAIT_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: T_ARM and T_FIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_WAIT_LOW:  if (!evt_s) state_d = EV_WAIT_HIGH;
            EV_WAIT_HIGH: if (evt_s)  state_d = EV_WAIT_LOW;
            default:      state_d = EV_WAIT_LOW;
        endcase
    end

    // outputs
    always_comb begin
        evt_fire = 1'b0;
        unique case (state_q)
            EV_WAIT_LOW:  evt_fire = 1'b0;
            EV_WAIT_HIGH: evt_fire = evt_s;
            default:      evt_fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsc_bcd_digit.sv
module dsc_bcd_digit
    import dsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    output bcd_t value,
    output logic at_nine
);
    localparam bcd_t MAX_VAL = bcd_t'(9);

    bcd_t value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (step) begin
            value_q <= (value_q == MAX_VAL) ? '0 : value_q + bcd_t'(1);
        end
    end

    assign value   = value_q;
    assign at_nine = (value_q == MAX_VAL);
endmodule

// File: rtl/dsc_seg_decode.sv
module dsc_seg_decode
    import dsc_pkg::*;
(
    input  bcd_t digit,
    output seg_t seg
);
    // bit 0 = a ... bit 6 = g, active high
    always_comb begin
        unique case (digit)
            4'd0:    seg = 7'h3F;
            4'd1:    seg = 7'h06;
            4'd2:    seg = 7'h5B;
            4'd3:    seg = 7'h4F;
            4'd4:    seg = 7'h66;
            4'd5:    seg = 7'h6D;
            4'd6:    seg = 7'h7D;
            4'd7:    seg = 7'h07;
            4'd8:    seg = 7'h7F;
            4'd9:    seg = 7'h6F;
            default: seg = 7'h00;
        endcase
    end
endmodule

// File: rtl/dsc_scan_ctrl.sv
module dsc_scan_ctrl
    import dsc_pkg::*;
#(
    parameter int SCAN_DIV = 1000
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic [SEL_W-1:0]      sel_idx,
    output logic [NUM_DIGITS-1:0] dig_sel
);
    localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCAN_DIV - 1);

    logic [DIV_W-1:0] pre_q;
    logic             tick;
    scan_state_t      state_q;
    scan_state_t      state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end

    assign tick = (pre_q == DIV_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_D0;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: T_NEXT on each prescaler tick
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                SCAN_D0: state_d = SCAN_D1;
                SCAN_D1: state_d = SCAN_D2;
                SCAN_D2: state_d = SCAN_D3;
                SCAN_D3: state_d = SCAN_D0;
                default: state_d = SCAN_D0;
            endcase
        end
    end

    // outputs decoded from the state register only
    always_comb begin
        unique case (state_q)
            SCAN_D0: begin sel_idx = 2'd0; dig_sel = 4'b0001; end
            SCAN_D1: begin sel_idx = 2'd1; dig_sel = 4'b0010; end
            SCAN_D2: begin sel_idx = 2'd2; dig_sel = 4'b0100; end
            SCAN_D3: begin sel_idx = 2'd3; dig_sel = 4'b1000; end
            default: begin sel_idx = 2'd0; dig_sel = 4'b0001; end
        endcase
    end
endmodule

// File: rtl/dec_scan_counter.sv
module dec_scan_counter
    import dsc_pkg::*;
#(
    parameter int SCAN_DIV      = 1000,
    parameter bit PARALLEL_MODE = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cnt_en,
    input  logic                        evt_in,
    output logic [SEG_W-1:0]            seg_bus,
    output logic [NUM_DIGITS-1:0]       dig_sel,
    output logic [NUM_DIGITS*SEG_W-1:0] seg_par
);
    logic                           evt_fire;
    logic [NUM_DIGITS:0]            carry;
    logic [NUM_DIGITS-1:0]          at_nine;
    bcd_t                           digit_val [NUM_DIGITS];
    logic [NUM_DIGITS*BCD_W-1:0]    count_bcd;

    dsc_event_qual #(.SYNC_STAGES(2)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .evt_raw  (evt_in),
        .evt_fire (evt_fire)
    );

    assign carry[0] = evt_fire & cnt_en;

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
        dsc_bcd_digit u_dig (
            .clk     (clk),
            .rst     (rst),
            .step    (carry[k]),
            .value   (digit_val[k]),
            .at_nine (at_nine[k])
        );
        assign carry[k+1] = carry[k] & at_nine[k];
        assign count_bcd[k*BCD_W +: BCD_W] = digit_val[k];
    end

    if (PARALLEL_MODE) begin : g_par
        for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dec
            dsc_seg_decode u_dec (
                .digit (digit_val[k]),
                .seg   (seg_par[k*SEG_W +: SEG_W])
            );
        end
        assign seg_bus = '0;
        assign dig_sel = '0;
    end else begin : g_scan
        logic [SEL_W-1:0] sel_idx;
        bcd_t             cur_digit;

        dsc_scan_ctrl #(.SCAN_DIV(SCAN_DIV)) u_scan (
            .clk     (clk),
            .rst     (rst),
            .sel_idx (sel_idx),
            .dig_sel (dig_sel)
        );

        // mux follows the state register combinationally: no stale cycle
        assign cur_digit = digit_val[sel_idx];

        dsc_seg_decode u_dec (
            .digit (cur_digit),
            .seg   (seg_bus)
        );
        assign seg_par = '0;
    end
endmodule

// File: rtl/dec_scan_counter_chk.sv
module dec_scan_counter_chk #(
    parameter int SCAN_DIV      = 1000,
    parameter bit PARALLEL_MODE = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        cnt_en,
    input logic [6:0]  seg_bus,
    input logic [3:0]  dig_sel,
    input logic [27:0] seg_par,
    input logic [15:0] count_bcd
);
    function automatic int bcd2int(input logic [15:0] b);
        return b[15:12]*1000 + b[11:8]*100 + b[7:4]*10 + b[3:0];
    endfunction

    function automatic bit legal_code(input logic [6:0] s);
        return s == 7'h3F || s == 7'h06 || s == 7'h5B || s == 7'h4F || s == 7'h66 ||
               s == 7'h6D || s == 7'h7D || s == 7'h07 || s == 7'h7F || s == 7'h6F;
    endfunction

    int   count_i;
    int   phase_q;
    logic rst_d;

    assign count_i = bcd2int(count_bcd);

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            phase_q <= 0;
        end else begin
            phase_q <= (phase_q == SCAN_DIV - 1) ? 0 : phase_q + 1;
        end
    end

    // R1: state visible one cycle after a reset edge
    always @(posedge clk) begin
        if (rst_d) begin
            assert_reset_state_R1: assert (count_bcd == 16'h0000 &&
                (PARALLEL_MODE ? (dig_sel == 4'b0000) : (dig_sel == 4'b0001)));
        end
    end

    // R2 / R4 / R5: only single decimal steps
    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && count_bcd != $past(count_bcd)) |->
            (count_i == ((bcd2int($past(count_bcd)) + 1) % 10000)));

    // R3
    assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count_bcd));

    if (PARALLEL_MODE) begin : g_par_chk
        assert_scan_idle_R9: assert property (@(posedge clk) disable iff (rst)
            (seg_bus == 7'h00 && dig_sel == 4'b0000));
    end else begin : g_scan_chk
        assert_onehot_sel_R7: assert property (@(posedge clk) disable iff (rst)
            $countones(dig_sel) == 1);

        assert_rotate_timing_R7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && dig_sel != $past(dig_sel)) |->
                ($past(phase_q) == SCAN_DIV - 1 &&
                 dig_sel == {$past(dig_sel[2:0]), $past(dig_sel[3])}));

        assert_legal_code_R6: assert property (@(posedge clk) disable iff (rst)
            legal_code(seg_bus));

        assert_par_idle_R9: assert property (@(posedge clk) disable iff (rst)
            seg_par == 28'h0);
    end
endmodule

bind dec_scan_counter dec_scan_counter_chk #(
    .SCAN_DIV      (SCAN_DIV),
    .PARALLEL_MODE (PARALLEL_MODE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .seg_bus   (seg_bus),
    .dig_sel   (dig_sel),
    .seg_par   (seg_par),
    .count_bcd (count_bcd)
);

// File: tb/dec_scan_counter_tb.sv
`timescale 1ns/1ps
module dec_scan_counter_tb;
    localparam int DIV = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        evt_in = 1'b0;
    logic [6:0]  seg_bus, seg_bus_p;
    logic [3:0]  dig_sel, dig_sel_p;
    logic [27:0] seg_par, seg_par_s;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int model    = 0;
    bit done     = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    dec_scan_counter #(.SCAN_DIV(DIV), .PARALLEL_MODE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .evt_in(evt_in),
        .seg_bus(seg_bus), .dig_sel(dig_sel), .seg_par(seg_par_s));

    dec_scan_counter #(.SCAN_DIV(DIV), .PARALLEL_MODE(1'b1)) u_dut_par (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .evt_in(evt_in),
        .seg_bus(seg_bus_p), .dig_sel(dig_sel_p), .seg_par(seg_par));

    // R6 table
    function automatic logic [6:0] code_of(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
        endcase
    endfunction

    function automatic int digit_of(input int value, input int k);
        int v = value;
        for (int i = 0; i < k; i++) v = v / 10;
        return v % 10;
    endfunction

    function automatic logic [27:0] par_expect(input int value);
        logic [27:0] r;
        for (int k = 0; k < 4; k++) r[k*7 +: 7] = code_of(digit_of(value, k));
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_count(input string req);
        check(seg_par == par_expect(model), req, int'(seg_par), int'(par_expect(model)));
    endtask

    task automatic check_scan();
        int idx = -1;
        for (int k = 0; k < 4; k++) if (dig_sel == (4'b0001 << k)) idx = k;
        check(idx >= 0, "R7", int'(dig_sel), 1);
        if (idx >= 0)
            check(seg_bus == code_of(digit_of(model, idx)), "R8",
                  int'(seg_bus), int'(code_of(digit_of(model, idx))));
        check(seg_par_s == 28'h0 && seg_bus_p == 7'h0 && dig_sel_p == 4'h0, "R9",
              int'(seg_par_s), 0);
    endtask

    task automatic pulse(input bit en, input int hi, input int lo);
        @(negedge clk);
        cnt_en = en;
        evt_in = 1'b1;
        repeat (hi) @(negedge clk);
        evt_in = 1'b0;
        repeat (lo) @(negedge clk);
        if (en) model = (model + 1) % 10000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = 0;
    endtask

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_count("R1");
        check(dig_sel == 4'b0001, "R1", int'(dig_sel), 1);

        // R2 basic counting
        for (int i = 0; i < 9; i++) pulse(1'b1, 3, 3);
        check_count("R2");
        check_scan();
        // R4 first carry
        pulse(1'b1, 3, 3);
        check_count("R4");
        // R2 long-held input counts once
        pulse(1'b1, 40, 4);
        check_count("R2");
        // R3 disabled edge, then enable without new edge
        pulse(1'b0, 4, 4);
        cnt_en = 1'b1;
        repeat (6) @(negedge clk);
        check_count("R3");

        // random mix
        for (int i = 0; i < 150; i++) begin
            pulse(1'($urandom_range(0, 3) != 0), $urandom_range(3, 6), $urandom_range(3, 6));
            if (i % 10 == 0) begin
                check_count(model == 0 ? "R5" : "R2");
                check_scan();
            end
        end
        check_count("R3");

        // R1 reset mid-count, then R7 schedule
        evt_in = 1'b1;
        do_reset();
        check_count("R1");
        check(dig_sel == 4'b0001, "R1", int'(dig_sel), 1);
        evt_in = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            check(dig_sel == (4'b0001 << ((k / DIV) % 4)), "R7",
                  int'(dig_sel), int'(4'b0001 << ((k / DIV) % 4)));
        end
        // high input at reset must not have counted
        check_count("R1");

        // R4 / R5 full sweep
        do_reset();
        for (int i = 0; i < 9999; i++) begin
            pulse(1'b1, 3, 3);
            if (model == 99 || model == 100 || model == 999 || model == 1000) check_count("R4");
        end
        check_count("R5");
        check_scan();
        pulse(1'b1, 3, 3);
        check_count("R5");
        check_scan();

        done = 1;
    end

    initial begin
        wait (done || cycles >= 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule